// File: doc/BRIEF.md
# Timer Input Capture Unit

This block is the timestamp half of a small microcontroller timer. A 16-bit counter runs freely, stepping once every four system clocks through a fixed divide-by-four prescaler. An external pin is brought into the clock domain through a two-flop synchronizer, and a transition of the chosen polarity (rising or falling, picked by one control input) records a timestamp in a 16-bit capture register and raises a capture flag.

The recorded value is one more than the counter value that was present when the pin changed, so software sees a fixed offset for the synchronizer delay. The offset does not depend on where the change falls within the prescaler period. Every qualifying transition overwrites the timestamp, whatever the state of the flag. The timestamp is not cleared by reset. Software reads the timestamp as two bytes through a combinational read port. The flag is cleared by a write-one strobe.

Top module: `tcap_top`

## Requirements
- R1: While reset is asserted and just after it is released, the counter reads 0xFFFC, the prescaler phase is zero and the capture flag is 0.
- R2: After reset is released, the counter reads 0xFFFC + floor(n/4) modulo 65536 after n rising clock edges, so it goes from 0xFFFF to 0x0000 at n = 16.
- R3: Suppose the pin changes while the counter shows C (after the last clock edge before the change). Three rising edges later, the timestamp equals (C + 1) modulo 65536, whatever the prescaler phase.
- R4: When edge_rise is 1, only a 0-to-1 transition of the pin captures. When it is 0, only a 1-to-0 transition captures. A transition of the other polarity leaves the timestamp and the flag unchanged.
- R5: A capture sets cap_flag in the same clock edge that loads the timestamp. Without a capture or a clear, the flag holds its value.
- R6: A high flag_clr for one clock clears cap_flag. If a capture lands on the same edge as the clear, the flag ends up set.
- R7: A capture overwrites the timestamp even when cap_flag is already set.
- R8: Asserting and releasing reset leaves the timestamp unchanged.
- R9: reg_rdata shows timestamp bits 15:8 when reg_addr is 0x4 and bits 7:0 when reg_addr is 0x5. Every other address reads 0x00. The port has no write path, so the timestamp is read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| cap_pin | input | 1 | External capture input, asynchronous to clk |
| edge_rise | input | 1 | Capture polarity: 1 rising, 0 falling |
| flag_clr | input | 1 | Write-one strobe that clears the capture flag |
| reg_addr | input | 4 | Register read address |
| reg_rdata | output | 8 | Selected timestamp byte, combinational on reg_addr |
| cap_flag | output | 1 | Capture flag |
| timer_count | output | 16 | Free-running counter value |

## Verification
Captures are triggered after idle gaps of zero to nine clocks, so the pin change falls at every phase of the divide-by-four prescaler. This separates a timestamp taken when the pin changed from one taken when the capture completes. Each capture is followed by a transition of the opposite polarity, under both settings of the polarity input, which shows that the wrong edge is rejected. The gaps alternate between clearing the flag and leaving it set, which exercises overwriting on a set flag. One capture is placed exactly on a clear strobe. A capture at counter value 0xFFFF right after a reset checks the wrap of the plus-one offset, and a preceding reset shows that the timestamp survives.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  function automatic int unsigned phase_width(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_DIV = 4,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o
);
  import tcap_pkg::*;

  localparam int unsigned PW = phase_width(PRE_DIV);
  localparam logic [PW-1:0] LAST_PHASE = PW'(PRE_DIV - 1);

  logic [PW-1:0]    phase_q, phase_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             tick;

  always_comb begin
    tick    = (phase_q == LAST_PHASE);
    phase_d = tick ? '0 : phase_q + PW'(1);
    count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      count_q <= RST_VAL;
    end else begin
      phase_q <= phase_d;
      if (tick) count_q <= count_d;
    end
  end

  assign count_o = count_q;
  assign tick_o  = tick;

  // R2: a prescaler tick advances the count by exactly one
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (count_o == $past(count_o) + CNT_W'(1)));

  // R2: between ticks the count holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(count_o));

endmodule

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_i,
  input  tcap_pkg::edge_sel_e  edge_sel_i,
  input  logic [CNT_W-1:0]     count_i,
  output logic                 stb_o,
  output logic [CNT_W-1:0]     stamp_o
);
  import tcap_pkg::*;

  // lvl_q[STAGES-1] is the synchronized level, lvl_q[STAGES] its previous value
  logic [STAGES:0]  lvl_q, lvl_d;
  logic [CNT_W-1:0] stamp_q [STAGES];
  logic             lvl_now, lvl_prev, rise, fall;

  always_comb begin
    lvl_d    = {lvl_q[STAGES-1:0], pin_i};
    lvl_now  = lvl_q[STAGES-1];
    lvl_prev = lvl_q[STAGES];
    rise     = lvl_now & ~lvl_prev;
    fall     = ~lvl_now & lvl_prev;
    stb_o    = (edge_sel_i == EDGE_RISE) ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  // Counter value travels beside the pin level, one slot per synchronizer stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stamp
    if (g == 0) begin : g_head
      always_ff @(posedge clk) stamp_q[g] <= count_i;
    end else begin : g_body
      always_ff @(posedge clk) stamp_q[g] <= stamp_q[g-1];
    end
  end

  assign stamp_o = stamp_q[STAGES-1];

  // R4: a strobe only fires on a real level change of the synchronized input
  p_edge_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> (lvl_now != lvl_prev));

  // R4: the new level matches the selected polarity
  p_edge_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> (lvl_now == (edge_sel_i == EDGE_RISE)));

endmodule

// File: rtl/tcap_capture_regs.sv
module tcap_capture_regs #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned HI_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [CNT_W-1:0]  stamp_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              flag_o
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(HI_ADDR + 1);

  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;

  always_comb begin
    cap_d  = stamp_i + CNT_W'(1);
    flag_d = stb_i | (flag_q & ~clr_i);
    if (addr_i == A_HI)      rdata_o = cap_q[CNT_W-1 -: BYTE_W];
    else if (addr_i == A_LO) rdata_o = cap_q[BYTE_W-1:0];
    else                     rdata_o = '0;
  end

  // Timestamp deliberately has no reset (R8)
  always_ff @(posedge clk) begin
    if (stb_i) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R5: a capture always leaves the flag set (also covers set-wins of R6)
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> flag_o);

  // R6: a clear without a capture drops the flag
  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !stb_i) |=> !flag_o);

  // R5: no capture and no clear means the flag holds
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_i && !clr_i) |=> $stable(flag_o));

  // R3: the timestamp changes only on a capture strobe
  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(cap_q));

endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_DIV = 4,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned HI_ADDR = 4,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_pin,
  input  logic                edge_rise,
  input  logic                flag_clr,
  input  logic [ADDR_W-1:0]   reg_addr,
  output logic [CNT_W/2-1:0]  reg_rdata,
  output logic                cap_flag,
  output logic [CNT_W-1:0]    timer_count
);
  import tcap_pkg::*;

  localparam int unsigned BYTE_W = CNT_W / 2;

  logic             tick;
  logic             cap_stb;
  logic [CNT_W-1:0] stamp;
  edge_sel_e        edge_sel;

  assign edge_sel = edge_sel_e'(edge_rise);

  tcap_counter #(
    .CNT_W(CNT_W), .PRE_DIV(PRE_DIV), .RST_VAL(RST_VAL)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_o(timer_count), .tick_o(tick)
  );

  tcap_edge_sync #(
    .CNT_W(CNT_W), .STAGES(STAGES)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .edge_sel_i(edge_sel),
    .count_i(timer_count), .stb_o(cap_stb), .stamp_o(stamp)
  );

  tcap_capture_regs #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .stb_i(cap_stb), .stamp_i(stamp),
    .clr_i(flag_clr), .addr_i(reg_addr), .rdata_o(reg_rdata), .flag_o(cap_flag)
  );

  // R2: ticks are spaced by the prescaler, so the count never moves on consecutive clocks
  p_no_double_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && PRE_DIV > 1) |=> !tick);

endmodule

// File: tb/sim_tcap_top.sv
module sim_tcap_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_HI = 4'h4;
  localparam logic [3:0] A_LO = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n, cap_pin, edge_rise, flag_clr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_rdata;
  logic        cap_flag;
  logic [15:0] timer_count;

  int n_chk = 0;
  int n_bad = 0;

  tcap_top u0 (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_rise(edge_rise),
    .flag_clr(flag_clr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .cap_flag(cap_flag), .timer_count(timer_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_cap(output logic [15:0] v);
    reg_addr = A_HI; #1 v[15:8] = reg_rdata;
    reg_addr = A_LO; #1 v[7:0]  = reg_rdata;
    reg_addr = 4'h0;
  endtask

  // drive the pin mid-cycle, return counter seen then, land at negedge after 3 edges
  task automatic pin_to(input logic lvl, output logic [15:0] c);
    @(negedge clk);
    c = timer_count;
    cap_pin = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    #1 check("R6 clear", {15'b0, cap_flag}, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c, v, prev;
    logic        trig;
    rst_n = 1'b0; cap_pin = 1'b0; edge_rise = 1'b1; flag_clr = 1'b0; reg_addr = 4'h0;
    repeat (3) @(posedge clk);
    #1 check("R1 count in reset", timer_count, 16'hFFFC);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 count", timer_count, 16'hFFFC);
    check("R1 flag", {15'b0, cap_flag}, 16'h0);
    for (int n = 1; n < 20; n++) begin
      @(negedge clk); #1;
      check("R2 count", timer_count, 16'hFFFC + 16'(n / 4));
    end

    // sweep both polarities and all prescaler phases
    for (int pol = 1; pol >= 0; pol--) begin
      edge_rise = pol[0];
      trig = pol[0];
      if (pol == 0) begin
        read_cap(prev);
        pin_to(1'b1, c);
        read_cap(v);
        check("R4 rising ignored in falling mode", v, prev);
      end
      for (int gap = 0; gap < 10; gap++) begin
        repeat (gap) @(posedge clk);
        pin_to(trig, c);
        #1 read_cap(v);
        check("R3 stamp", v, c + 16'h1);
        check("R5 flag set", {15'b0, cap_flag}, 16'h1);
        prev = v;
        pin_to(~trig, c);
        #1 read_cap(v);
        check("R4 opposite edge no capture", v, prev);
        check("R4 flag unchanged", {15'b0, cap_flag}, 16'h1);
        if (gap[0]) pulse_clr();
        else        check("R7 flag still set before next capture", {15'b0, cap_flag}, 16'h1);
      end
    end

    // R6: capture on the same edge as a clear, falling mode, pin now high
    @(negedge clk);
    c = timer_count;
    cap_pin = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk); flag_clr = 1'b0;
    #1 check("R6 set wins", {15'b0, cap_flag}, 16'h1);
    read_cap(v);
    check("R6 stamp with clear", v, c + 16'h1);

    // R9: address decode
    reg_addr = A_HI; #1 check("R9 high byte", {8'h0, reg_rdata}, {8'h0, v[15:8]});
    reg_addr = A_LO; #1 check("R9 low byte", {8'h0, reg_rdata}, {8'h0, v[7:0]});
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 5) begin
        reg_addr = 4'(a); #1 check("R9 unmapped address", {8'h0, reg_rdata}, 16'h0);
      end
    end
    reg_addr = 4'h0;

    // R8: reset keeps the timestamp
    @(negedge clk); rst_n = 1'b0; edge_rise = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 read_cap(prev);
    check("R8 stamp kept over reset", prev, v);
    check("R1 flag after reset", {15'b0, cap_flag}, 16'h0);
    check("R1 count after reset", timer_count, 16'hFFFC);

    // R3 wrap: capture while counter shows 0xFFFF
    repeat (11) @(negedge clk);
    pin_to(1'b1, c);
    check("R2 count before wrap", c, 16'hFFFF);
    #1 read_cap(v);
    check("R3 stamp wraps", v, 16'h0000);
    check("R5 flag after wrap capture", {15'b0, cap_flag}, 16'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule